// File: doc/BRIEF.md
# Switch Fault Filter and Error Flag Encoder

This block sits between the fault comparators of an H-bridge gate driver and its four gate drive stages. For every switch it receives a synchronized short-circuit level and an undervoltage level, and it receives one overtemperature level for the whole die. It produces one enable bit per switch and two active-low error flags. Switches are numbered 0 to 3. Switches 2k and 2k+1 form half-bridge k, so the even switch is the high side and the odd switch is the low side.

A short-circuit level must stay high for `FILT_CYC` consecutive clock edges before it counts. Each switch has its own counter, and that counter restarts whenever its level drops, so short events never add up. A confirmed short circuit latches the whole half-bridge off. The latch holds until a clear pulse from the disable decoder or an inhibit. An undervoltage level masks only its own switch, and the switch comes back on its own when the level clears. Overtemperature is only reported and never masks a switch. Inhibit puts the block in a known state: it clears every counter and latch, holds all enables low and leaves both flags inactive.

Top module: `fault_diag`

## Requirements
- R1: When `sc_i[i]` is high at `FILT_CYC` consecutive rising edges, half-bridge i/2 latches off at the last of those edges. From then on both of its `sw_en_o` bits read 0.
- R2: A run of `sc_i[i]` that lasts fewer than `FILT_CYC` edges causes no shutdown, however often it repeats. A low at any edge restarts that switch's count from zero.
- R3: A latched half-bridge stays off after `sc_i` drops. It returns to enabled at the first edge where `clr_i` is high.
- R4: A short-circuit latch disables only the two switches of its own half-bridge. The other half-bridge stays enabled.
- R5: `uv_i[i]` high clears only `sw_en_o[i]`, in the same cycle and without a clock edge. The bit returns to 1 as soon as `uv_i[i]` is low, and nothing is latched.
- R6: The error flags {`err1_o`,`err2_o`} read 2'b11 with no fault, 2'b10 for overtemperature only, 2'b01 when any half-bridge is latched by a short circuit, and 2'b00 when any `uv_i` bit is high.
- R7: When an undervoltage and a short-circuit latch are present together, the flags read 2'b00.
- R8: When overtemperature coincides with any shutdown, the flags report the shutdown code and not 2'b10.
- R9: `ot_i` never changes `sw_en_o`.
- R10: While `inh_i` is high, `sw_en_o` is 4'b0000 and the flags are 2'b11. Every edge with `inh_i` high clears all latches and filter counters. A short-circuit run that began before inhibit must therefore start again at full length.
- R11: After reset, with no fault input active, `sw_en_o` is 4'b1111 and the flags are 2'b11.
- R12: When `clr_i` and a new confirmation arrive at the same edge, the clear wins. If `sc_i` is still high, the half-bridge latches again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sc_i | input | 4 | Short-circuit level per switch |
| uv_i | input | 4 | Undervoltage level per switch |
| ot_i | input | 1 | Overtemperature warning level |
| clr_i | input | 1 | Error latch clear pulse from the disable decoder |
| inh_i | input | 1 | Inhibit and reinitialize |
| sw_en_o | output | 4 | Per-switch enable, 1 allows the gate to drive |
| err1_o | output | 1 | Error flag 1, active low |
| err2_o | output | 1 | Error flag 2, active low |

## Verification
The undervoltage mask, the inhibit mask and both flags are combinational from the inputs and the latch state. The bench therefore checks them in the same cycle in which it drives the inputs. A short-circuit shutdown appears just after the `FILT_CYC`-th edge with `sc_i` high. A clear or inhibit acts at the edge where it is high. The bench checks one edge before and at each of these edges to pin down their exact timing. Inputs are driven and outputs sampled 2 ns after the rising edge, so no check races the clock.

// File: rtl/fault_pkg.sv
package fault_pkg;
  // {err1, err2}, active low
  typedef enum logic [1:0] {
    DIAG_UV = 2'b00,
    DIAG_SC = 2'b01,
    DIAG_OT = 2'b10,
    DIAG_OK = 2'b11
  } diag_e;
endpackage

// File: rtl/fd_sc_filter.sv
module fd_sc_filter #(
  parameter int FILT_CYC = 1125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inh_i,
  input  logic sc_i,
  output logic hit_o
);
  localparam int CW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (inh_i || !sc_i)       cnt_q <= '0;
    else if (cnt_q != LAST)        cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = sc_i && !inh_i && (cnt_q == LAST);

  // R2
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_i |=> cnt_q == '0);
  // R1
  hit_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(sc_i));
endmodule

// File: rtl/fd_hb_latch.sv
module fd_hb_latch #(
  parameter int N_HB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2*N_HB-1:0] hit_i,
  input  logic              clr_i,
  input  logic              inh_i,
  output logic [N_HB-1:0]   lat_o
);
  logic [N_HB-1:0] lat_q;

  for (genvar k = 0; k < N_HB; k++) begin : g_hb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lat_q[k] <= 1'b0;
      else if (clr_i || inh_i)                   lat_q[k] <= 1'b0;
      else if (hit_i[2*k] || hit_i[2*k+1])       lat_q[k] <= 1'b1;
    end
  end

  assign lat_o = lat_q;

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q != '0) && !clr_i && !inh_i |=> ($past(lat_q) & ~lat_q) == '0);
  // R12
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> lat_q == '0);
endmodule

// File: rtl/fd_diag_enc.sv
module fd_diag_enc
  import fault_pkg::*;
#(
  parameter int N_SW = 4
) (
  input  logic [N_SW-1:0] uv_i,
  input  logic            sc_lat_i,
  input  logic            ot_i,
  input  logic            inh_i,
  output logic            err1_o,
  output logic            err2_o
);
  diag_e code;

  always_comb begin
    if (inh_i)          code = DIAG_OK;
    else if (|uv_i)     code = DIAG_UV;
    else if (sc_lat_i)  code = DIAG_SC;
    else if (ot_i)      code = DIAG_OT;
    else                code = DIAG_OK;
  end

  assign {err1_o, err2_o} = code;
endmodule

// File: rtl/fault_diag.sv
module fault_diag #(
  parameter int N_HB     = 2,
  parameter int FILT_CYC = 1125
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2*N_HB-1:0] sc_i,
  input  logic [2*N_HB-1:0] uv_i,
  input  logic              ot_i,
  input  logic              clr_i,
  input  logic              inh_i,
  output logic [2*N_HB-1:0] sw_en_o,
  output logic              err1_o,
  output logic              err2_o
);
  localparam int N_SW = 2 * N_HB;

  logic [N_SW-1:0] hit;
  logic [N_HB-1:0] lat;
  logic [N_SW-1:0] lat_sw;

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    fd_sc_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inh_i (inh_i),
      .sc_i  (sc_i[i]),
      .hit_o (hit[i])
    );
    assign lat_sw[i] = lat[i/2];
  end

  fd_hb_latch #(.N_HB(N_HB)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit),
    .clr_i (clr_i),
    .inh_i (inh_i),
    .lat_o (lat)
  );

  fd_diag_enc #(.N_SW(N_SW)) u_enc (
    .uv_i    (uv_i),
    .sc_lat_i(|lat),
    .ot_i    (ot_i),
    .inh_i   (inh_i),
    .err1_o  (err1_o),
    .err2_o  (err2_o)
  );

  assign sw_en_o = inh_i ? '0 : ~(uv_i | lat_sw);

  // R7
  sc_code_no_uv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err1_o && err2_o) |-> uv_i == '0);
  // R10
  inh_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_i |-> (sw_en_o == '0) && err1_o && err2_o);
  // R4
  pair_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i == '0) && !inh_i |-> sw_en_o[0] == sw_en_o[1]);
endmodule

// File: tb/fault_diag_tb.sv
module fault_diag_tb;
  localparam int FILT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sc = '0, uv = '0;
  logic       ot = 1'b0, clr = 1'b0, inh = 1'b0;
  logic [3:0] en;
  logic       e1, e2;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  fault_diag #(.N_HB(2), .FILT_CYC(FILT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sc_i(sc), .uv_i(uv), .ot_i(ot),
    .clr_i(clr), .inh_i(inh), .sw_en_o(en), .err1_o(e1), .err2_o(e2)
  );

  // uv, ot -> en, err1, err2
  localparam logic [10:0] VEC [6] = '{
    {4'b0000, 1'b0, 4'b1111, 2'b11},
    {4'b0000, 1'b1, 4'b1111, 2'b10},
    {4'b0001, 1'b0, 4'b1110, 2'b00},
    {4'b0100, 1'b1, 4'b1011, 2'b00},
    {4'b1010, 1'b0, 4'b0101, 2'b00},
    {4'b1111, 1'b1, 4'b0000, 2'b00}
  };

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [3:0] exp_en, logic [1:0] exp_f);
    n_chk++;
    if (en !== exp_en || {e1, e2} !== exp_f) begin
      n_fail++;
      $display("FAIL %s: en=%b flags=%b%b expected en=%b flags=%b",
               req, en, e1, e2, exp_en, exp_f);
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(); clr = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    chk("R11 reset state", 4'b1111, 2'b11);

    // R5 R6 R8 R9: table of undervoltage and overtemperature patterns
    for (int v = 0; v < 6; v++) begin
      uv = VEC[v][10:7]; ot = VEC[v][6];
      #1;
      chk("R5/R6 vector", VEC[v][5:2], VEC[v][1:0]);
      tick();
    end
    uv = '0; ot = 1'b0;
    #1 chk("R5 uv released", 4'b1111, 2'b11);

    // R2: repeated short runs never trip
    for (int r = 0; r < 3; r++) begin
      sc[2] = 1'b1; tick(FILT - 1);
      sc[2] = 1'b0; tick();
    end
    chk("R2 short runs", 4'b1111, 2'b11);

    // R1 R4: full run trips half-bridge 1 only
    sc[2] = 1'b1; tick(FILT - 1);
    chk("R1 one edge before trip", 4'b1111, 2'b11);
    tick();
    chk("R1 R4 trip", 4'b0011, 2'b01);

    // R3: holds after the level drops
    sc[2] = 1'b0; tick(5);
    chk("R3 latch holds", 4'b0011, 2'b01);

    // R8 R9
    ot = 1'b1; #1;
    chk("R8 R9 ot with shutdown", 4'b0011, 2'b01);
    ot = 1'b0;

    // R7
    uv[0] = 1'b1; #1;
    chk("R7 uv over sc", 4'b0010, 2'b00);
    uv[0] = 1'b0; #1;

    pulse_clr();
    chk("R3 clear", 4'b1111, 2'b11);

    // R12: persistent sc, clear then relatch
    sc[1] = 1'b1; tick(FILT);
    chk("R12 trip hb0", 4'b1100, 2'b01);
    clr = 1'b1; tick(); clr = 1'b0;
    chk("R12 clear wins", 4'b1111, 2'b11);
    tick();
    chk("R12 relatch", 4'b1100, 2'b01);
    sc[1] = 1'b0; tick();
    pulse_clr();
    chk("R3 clear hb0", 4'b1111, 2'b11);

    // R10: inhibit masks and clears latch
    sc[0] = 1'b1; tick(FILT);
    sc[0] = 1'b0;
    inh = 1'b1; #1;
    chk("R10 inhibit outputs", 4'b0000, 2'b11);
    tick(); inh = 1'b0; #1;
    chk("R10 latch cleared", 4'b1111, 2'b11);

    // R10: counter restarts after inhibit
    sc[3] = 1'b1; tick(FILT - 1);
    inh = 1'b1; tick(); inh = 1'b0;
    tick(FILT - 1);
    chk("R10 count restarted", 4'b1111, 2'b11);
    tick();
    chk("R10 full run after inhibit", 4'b0011, 2'b01);
    sc[3] = 1'b0; tick();
    pulse_clr();
    chk("R3 final clear", 4'b1111, 2'b11);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule